// File: doc/BRIEF.md
# Palette DAC Host Register Interface

This block is the processor-facing register decoder of a palette DAC with an extended register set. A host reaches it through four byte offsets and two extra select lines, giving sixteen register slots. It holds the pixel mask, an 8-bit command register, and a sixteen-entry overlay colour store. The overlay store is written and read one colour component at a time, in red, green, blue order. The main 256-entry palette appears here only as its index and component-phase logic; the colour RAM and the analog stage sit elsewhere.

The command register has its own direct slot. It can also be reached through the ordinary mask offset by a hidden unlock: a fixed run of consecutive mask reads redirects that offset to the command register. The redirection lasts until one of the other three offsets is touched. The pixel mask and the three upper command bits are driven out continuously for the pixel path.

Read data is combinational from the current state and the presented address, valid while `rd_stb` is high. All side effects of an access take place at the rising clock edge on which the strobe is sampled.

Top module: `paldac_host_regs`

## Requirements
- R1: After a synchronous active-low reset, `pix_mask` is FFh and every other register is zero: the command register, all four indices, the component phases, the unlock state and the overlay entries.
- R2: The slot number is `{host_sel, host_addr}`. `host_addr` encodes 0 = write index, 1 = data, 2 = pixel mask, 3 = read index. `host_sel[0]` is the lower extra select and `host_sel[1]` the upper one.
- R3: Slot 6 reads and writes the command register directly at all times. Command bit 5 drives `cmd_two_clk`, bit 6 drives `cmd_sixteen` and bit 7 drives `cmd_hicolor`. These outputs change only on a write.
- R4: Reads of slot 2 arm the unlock after `UNLOCK_READS` consecutive reads (default 4). Each of those arming reads returns the mask. Every later read or write of slot 2 reaches the command register.
- R5: While the unlock is armed, it persists across any number of slot 2 accesses. A write to slot 2 in that state leaves the pixel mask unchanged.
- R6: Any access whose `host_addr` is not 2, with any `host_sel` value, disarms the unlock and clears the read count. This includes a read of the write-index offset. A write to slot 2 while disarmed updates the mask and clears the read count.
- R7: Slot 4 is the 4-bit overlay write index and slot 7 the 4-bit overlay read index. Both are readable, with the value in bits 3:0 and zeros above.
- R8: Writes to slot 5 store `wr_data[5:0]` into the red, green and blue fields, in that order, of the overlay entry at the write index. Reads of slot 5 return `{2'b00, component}` in the same order from the entry at the read index. The index used by an access increments after its blue byte and wraps from 15 to 0.
- R9: The overlay store and the palette each have one component phase, shared by their reads and writes. Writing either index of a store returns that phase to red.
- R10: Slot 0 is the 8-bit palette write index and slot 3 the 8-bit palette read index, both readable. Accesses to slot 1 step the phase and indices exactly as in R8 and R9, and reads of slot 1 return zero.
- R11: Slots 8 to 15 and slot 2 with a nonzero select (slots 10 and 14) read zero, and writes to them are ignored. When `wr_stb` and `rd_stb` are both high, the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 2 | Base offset: 0 write index, 1 data, 2 mask, 3 read index |
| host_sel | input | 2 | Extra register-select lines (bit 0 low, bit 1 high) |
| rd_stb | input | 1 | Read strobe, one access per sampled cycle |
| wr_stb | input | 1 | Write strobe, one access per sampled cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the presented slot |
| pix_mask | output | 8 | Pixel mask for the pixel path |
| cmd_two_clk | output | 1 | Command bit 5: two clocks latch the two bytes of a pixel |
| cmd_sixteen | output | 1 | Command bit 6: 16-bit colour select |
| cmd_hicolor | output | 1 | Command bit 7: direct-colour enable |

## Verification
The bench targets the read count around the unlock. A counter that is off by one either reaches the command register one read early, so the fourth read returns command data, or one read late, so the first redirected access still returns the mask. It also checks that reads of the write-index offset and writes to the mask restart the count; if they did not, three old reads plus one new read would unlock.

Persistence is checked by repeated slot 2 accesses after unlocking, which a one-shot unlock would fail. Mask protection is checked by reading the mask back after a redirected write, which a design that wrote both registers would corrupt.

For the colour stores, the bench writes an index in the middle of a component triple and checks that the next data byte lands in red. It also checks that the 15-to-0 index wrap is seen at the index port, and that the phase is shared between reads and writes.

// File: rtl/paldac_pkg.sv
// Shared slot codes and the colour component phase type for the palette
// DAC host interface. Assumes a slot number of {select[1:0], offset[1:0]}.
package paldac_pkg;

    localparam logic [1:0] OFS_WIDX = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_MASK = 2'd2;
    localparam logic [1:0] OFS_RIDX = 2'd3;

    localparam logic [3:0] SLOT_PAL_WIDX = 4'h0;
    localparam logic [3:0] SLOT_PAL_DATA = 4'h1;
    localparam logic [3:0] SLOT_MASK     = 4'h2;
    localparam logic [3:0] SLOT_PAL_RIDX = 4'h3;
    localparam logic [3:0] SLOT_OVL_WIDX = 4'h4;
    localparam logic [3:0] SLOT_OVL_DATA = 4'h5;
    localparam logic [3:0] SLOT_CMD      = 4'h6;
    localparam logic [3:0] SLOT_OVL_RIDX = 4'h7;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } comp_ph_t;

    // Next component in red, green, blue order.
    function automatic comp_ph_t next_ph(input comp_ph_t ph);
        case (ph)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/paldac_unlock.sv
// Hidden unlock sequencer for the mask offset. Counts consecutive reads of
// the mask slot; after READS of them the mask offset is redirected to the
// command register until another offset is accessed.
// Assumes at most one access per cycle, already qualified by the caller.
module paldac_unlock #(
    parameter int READS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_rd,
    input  logic mask_wr,
    input  logic other_acc,
    output logic unlocked
);

    localparam int CNT_W = $clog2(READS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(READS - 1);

    logic [CNT_W-1:0] rd_cnt;

    // Count mask reads, arm on the last one, disarm on any other offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt   <= '0;
            unlocked <= 1'b0;
        end else if (other_acc) begin
            rd_cnt   <= '0;
            unlocked <= 1'b0;
        end else if (!unlocked) begin
            if (mask_wr) begin
                rd_cnt <= '0;
            end else if (mask_rd) begin
                if (rd_cnt == LAST) begin
                    rd_cnt   <= '0;
                    unlocked <= 1'b1;
                end else begin
                    rd_cnt <= rd_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/paldac_rgb_port.sv
// Index and component-phase engine for one colour store: a write index, a
// read index and one shared red/green/blue phase. With HAS_MEM set it also
// holds the colour entries; otherwise reads return zero.
// Assumes the caller never raises more than one request per cycle.
module paldac_rgb_port
    import paldac_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int COMP_W  = 6,
    parameter bit HAS_MEM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              widx_wr,
    input  logic              ridx_wr,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [COMP_W-1:0] dat_in,
    output logic [IDX_W-1:0]  widx,
    output logic [IDX_W-1:0]  ridx,
    output logic [COMP_W-1:0] dat_out
);

    localparam int DEPTH = 1 << IDX_W;

    comp_ph_t ph;

    // Index loads, phase stepping and increment after the blue component.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx <= '0;
            ridx <= '0;
            ph   <= PH_RED;
        end else if (widx_wr) begin
            widx <= idx_in;
            ph   <= PH_RED;
        end else if (ridx_wr) begin
            ridx <= idx_in;
            ph   <= PH_RED;
        end else if (dat_wr || dat_rd) begin
            ph <= next_ph(ph);
            if (ph == PH_BLU) begin
                if (dat_wr) widx <= widx + 1'b1;
                else        ridx <= ridx + 1'b1;
            end
        end
    end

    generate
        if (HAS_MEM) begin : g_mem
            logic [COMP_W-1:0] red_q [DEPTH];
            logic [COMP_W-1:0] grn_q [DEPTH];
            logic [COMP_W-1:0] blu_q [DEPTH];

            // Store one component into the entry at the write index.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        red_q[i] <= '0;
                        grn_q[i] <= '0;
                        blu_q[i] <= '0;
                    end
                end else if (dat_wr && !widx_wr && !ridx_wr) begin
                    case (ph)
                        PH_RED:  red_q[widx] <= dat_in;
                        PH_GRN:  grn_q[widx] <= dat_in;
                        default: blu_q[widx] <= dat_in;
                    endcase
                end
            end

            // Present the current component of the entry at the read index.
            always_comb begin
                case (ph)
                    PH_RED:  dat_out = red_q[ridx];
                    PH_GRN:  dat_out = grn_q[ridx];
                    default: dat_out = blu_q[ridx];
                endcase
            end
        end else begin : g_nomem
            logic unused_dat;
            assign unused_dat = ^dat_in;
            assign dat_out    = '0;
        end
    endgenerate

endmodule

// File: rtl/paldac_host_regs.sv
// Host register decoder of a palette DAC: sixteen slots over four offsets
// and two select lines, pixel mask, command register with hidden unlock,
// overlay store and palette index logic. Read data is combinational; all
// side effects happen on the clock edge that samples a strobe.
// Assumes strobes are single-cycle per access; a write wins over a read.
module paldac_host_regs
    import paldac_pkg::*;
#(
    parameter int UNLOCK_READS = 4,
    parameter int OVL_IDX_W    = 4,
    parameter int PAL_IDX_W    = 8,
    parameter int COMP_W       = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_addr,
    input  logic [1:0] host_sel,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [7:0] pix_mask,
    output logic       cmd_two_clk,
    output logic       cmd_sixteen,
    output logic       cmd_hicolor
);

    localparam int PAD_C = 8 - COMP_W;
    localparam int PAD_O = 8 - OVL_IDX_W;

    logic [3:0] slot;
    logic       is_wr, is_rd, any_acc;
    logic       unlocked;
    logic       cmd_hit, mask_hit;
    logic [7:0] cmd_q;

    logic [OVL_IDX_W-1:0] ovl_widx, ovl_ridx;
    logic [PAL_IDX_W-1:0] pal_widx, pal_ridx;
    logic [COMP_W-1:0]    ovl_dout, pal_dout;

    // Access qualification and slot decode.
    always_comb begin
        slot     = {host_sel, host_addr};
        is_wr    = wr_stb;
        is_rd    = rd_stb && !wr_stb;
        any_acc  = rd_stb || wr_stb;
        cmd_hit  = (slot == SLOT_CMD) || ((slot == SLOT_MASK) && unlocked);
        mask_hit = (slot == SLOT_MASK) && !unlocked;
    end

    paldac_unlock #(.READS(UNLOCK_READS)) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_rd   (is_rd && (slot == SLOT_MASK)),
        .mask_wr   (is_wr && (slot == SLOT_MASK)),
        .other_acc (any_acc && (host_addr != OFS_MASK)),
        .unlocked  (unlocked)
    );

    paldac_rgb_port #(.IDX_W(OVL_IDX_W), .COMP_W(COMP_W), .HAS_MEM(1'b1)) u_ovl (
        .clk     (clk),
        .rst_n   (rst_n),
        .widx_wr (is_wr && (slot == SLOT_OVL_WIDX)),
        .ridx_wr (is_wr && (slot == SLOT_OVL_RIDX)),
        .dat_wr  (is_wr && (slot == SLOT_OVL_DATA)),
        .dat_rd  (is_rd && (slot == SLOT_OVL_DATA)),
        .idx_in  (wr_data[OVL_IDX_W-1:0]),
        .dat_in  (wr_data[COMP_W-1:0]),
        .widx    (ovl_widx),
        .ridx    (ovl_ridx),
        .dat_out (ovl_dout)
    );

    paldac_rgb_port #(.IDX_W(PAL_IDX_W), .COMP_W(COMP_W), .HAS_MEM(1'b0)) u_pal (
        .clk     (clk),
        .rst_n   (rst_n),
        .widx_wr (is_wr && (slot == SLOT_PAL_WIDX)),
        .ridx_wr (is_wr && (slot == SLOT_PAL_RIDX)),
        .dat_wr  (is_wr && (slot == SLOT_PAL_DATA)),
        .dat_rd  (is_rd && (slot == SLOT_PAL_DATA)),
        .idx_in  (wr_data[PAL_IDX_W-1:0]),
        .dat_in  (wr_data[COMP_W-1:0]),
        .widx    (pal_widx),
        .ridx    (pal_ridx),
        .dat_out (pal_dout)
    );

    // Pixel mask and command register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_mask <= 8'hFF;
            cmd_q    <= 8'h00;
        end else if (is_wr) begin
            if (mask_hit) pix_mask <= wr_data;
            if (cmd_hit)  cmd_q    <= wr_data;
        end
    end

    // Read data multiplexer over the slot map.
    always_comb begin
        rd_data = 8'h00;
        if (cmd_hit) begin
            rd_data = cmd_q;
        end else begin
            case (slot)
                SLOT_PAL_WIDX: rd_data = pal_widx;
                SLOT_PAL_DATA: rd_data = {{PAD_C{1'b0}}, pal_dout};
                SLOT_MASK:     rd_data = pix_mask;
                SLOT_PAL_RIDX: rd_data = pal_ridx;
                SLOT_OVL_WIDX: rd_data = {{PAD_O{1'b0}}, ovl_widx};
                SLOT_OVL_DATA: rd_data = {{PAD_C{1'b0}}, ovl_dout};
                SLOT_OVL_RIDX: rd_data = {{PAD_O{1'b0}}, ovl_ridx};
                default:       rd_data = 8'h00;
            endcase
        end
    end

    assign cmd_two_clk = cmd_q[5];
    assign cmd_sixteen = cmd_q[6];
    assign cmd_hicolor = cmd_q[7];

endmodule

// File: rtl/paldac_host_regs_chk.sv
// Assertion checker for paldac_host_regs, attached by bind. Observes the
// host ports, the exported registers and the unlock state.
module paldac_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] host_addr,
    input logic [1:0] host_sel,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic [7:0] pix_mask,
    input logic       cmd_two_clk,
    input logic       cmd_sixteen,
    input logic       cmd_hicolor,
    input logic       unlocked
);

    // R3: command outputs move only on a write
    a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable({cmd_hicolor, cmd_sixteen, cmd_two_clk}));

    // R11: the mask moves only on a write
    a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(pix_mask));

    // R4: arming follows a read of the mask slot
    a_r4_unlock_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(rd_stb && !wr_stb && host_sel == 2'd0 && host_addr == 2'd2));

    // R5: a redirected write leaves the mask alone
    a_r5_mask_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && wr_stb && host_sel == 2'd0 && host_addr == 2'd2) |=> $stable(pix_mask));

    // R6: any other offset disarms the unlock
    a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb || wr_stb) && host_addr != 2'd2) |=> !unlocked);

endmodule

bind paldac_host_regs paldac_host_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_sel    (host_sel),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .pix_mask    (pix_mask),
    .cmd_two_clk (cmd_two_clk),
    .cmd_sixteen (cmd_sixteen),
    .cmd_hicolor (cmd_hicolor),
    .unlocked    (unlocked)
);

// File: tb/paldac_host_regs_test.sv
`timescale 1ns/1ps
module paldac_host_regs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic [1:0] host_sel = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] pix_mask;
    logic       cmd_two_clk, cmd_sixteen, cmd_hicolor;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    paldac_host_regs uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_sel    (host_sel),
        .rd_stb      (rd_stb),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .pix_mask    (pix_mask),
        .cmd_two_clk (cmd_two_clk),
        .cmd_sixteen (cmd_sixteen),
        .cmd_hicolor (cmd_hicolor)
    );

    // vector: {wr, slot[3:0], wdata[7:0], expect[7:0], check, req[3:0]}
    function automatic logic [25:0] v(input logic w, input logic [3:0] s,
                                      input logic [7:0] d, input logic [7:0] e,
                                      input logic c, input logic [3:0] r);
        return {w, s, d, e, c, r};
    endfunction

    localparam int NV = 98;
    localparam logic [25:0] VEC [NV] = '{
        // 1-3 reset values (R1)
        v(0,4'h2,8'h00,8'hFF,1,4'd1), v(0,4'h6,8'h00,8'h00,1,4'd1), v(0,4'h4,8'h00,8'h00,1,4'd1),
        // 4-6 direct command slot (R3)
        v(1,4'h6,8'hE0,8'h00,0,4'd3), v(0,4'h6,8'h00,8'hE0,1,4'd3), v(1,4'h6,8'h00,8'h00,0,4'd3),
        // 7-8 overlay write index (R7)
        v(1,4'h4,8'h03,8'h00,0,4'd7), v(0,4'h4,8'h00,8'h03,1,4'd7),
        // 9-14 two overlay entries, upper bits dropped (R8)
        v(1,4'h5,8'h11,8'h00,0,4'd8), v(1,4'h5,8'h22,8'h00,0,4'd8), v(1,4'h5,8'h33,8'h00,0,4'd8),
        v(1,4'h5,8'h15,8'h00,0,4'd8), v(1,4'h5,8'h6A,8'h00,0,4'd8), v(1,4'h5,8'h3F,8'h00,0,4'd8),
        // 15 write index advanced twice (R8)
        v(0,4'h4,8'h00,8'h05,1,4'd8),
        // 16-23 read back both entries (R8)
        v(1,4'h7,8'h03,8'h00,0,4'd8),
        v(0,4'h5,8'h00,8'h11,1,4'd8), v(0,4'h5,8'h00,8'h22,1,4'd8), v(0,4'h5,8'h00,8'h33,1,4'd8),
        v(0,4'h5,8'h00,8'h15,1,4'd8), v(0,4'h5,8'h00,8'h2A,1,4'd8), v(0,4'h5,8'h00,8'h3F,1,4'd8),
        v(0,4'h7,8'h00,8'h05,1,4'd8),
        // 24-27 read index write resets phase (R9)
        v(1,4'h7,8'h03,8'h00,0,4'd9), v(0,4'h5,8'h00,8'h11,1,4'd9),
        v(1,4'h7,8'h03,8'h00,0,4'd9), v(0,4'h5,8'h00,8'h11,1,4'd9),
        // 28-37 write index mid-triple restarts at red (R9)
        v(1,4'h4,8'h0A,8'h00,0,4'd9), v(1,4'h5,8'h3F,8'h00,0,4'd9), v(1,4'h4,8'h0A,8'h00,0,4'd9),
        v(1,4'h5,8'h01,8'h00,0,4'd9), v(1,4'h5,8'h02,8'h00,0,4'd9), v(1,4'h5,8'h03,8'h00,0,4'd9),
        v(1,4'h7,8'h0A,8'h00,0,4'd9),
        v(0,4'h5,8'h00,8'h01,1,4'd9), v(0,4'h5,8'h00,8'h02,1,4'd9), v(0,4'h5,8'h00,8'h03,1,4'd9),
        // 38-42 index wrap 15 -> 0 (R8)
        v(1,4'h4,8'h0F,8'h00,0,4'd8), v(1,4'h5,8'h01,8'h00,0,4'd8), v(1,4'h5,8'h01,8'h00,0,4'd8),
        v(1,4'h5,8'h01,8'h00,0,4'd8), v(0,4'h4,8'h00,8'h00,1,4'd8),
        // 43-49 four mask reads arm; writes reach command (R4)
        v(0,4'h2,8'h00,8'hFF,1,4'd4), v(0,4'h2,8'h00,8'hFF,1,4'd4),
        v(0,4'h2,8'h00,8'hFF,1,4'd4), v(0,4'h2,8'h00,8'hFF,1,4'd4),
        v(1,4'h2,8'hA0,8'h00,0,4'd4), v(0,4'h2,8'h00,8'hA0,1,4'd4), v(0,4'h6,8'h00,8'hA0,1,4'd3),
        // 50-52 persistence, cancel, mask untouched (R5, R6)
        v(0,4'h2,8'h00,8'hA0,1,4'd5), v(0,4'h3,8'h00,8'h00,1,4'd6), v(0,4'h2,8'h00,8'hFF,1,4'd5),
        // 53-63 write-index read restarts the count (R6)
        v(0,4'h0,8'h00,8'h00,1,4'd6),
        v(0,4'h2,8'h00,8'hFF,1,4'd6), v(0,4'h2,8'h00,8'hFF,1,4'd6), v(0,4'h2,8'h00,8'hFF,1,4'd6),
        v(0,4'h0,8'h00,8'h00,1,4'd6),
        v(0,4'h2,8'h00,8'hFF,1,4'd6), v(0,4'h2,8'h00,8'hFF,1,4'd6), v(0,4'h2,8'h00,8'hFF,1,4'd6),
        v(0,4'h2,8'h00,8'hFF,1,4'd4), v(0,4'h2,8'h00,8'hA0,1,4'd6), v(0,4'h3,8'h00,8'h00,1,4'd6),
        // 64-74 mask write while disarmed updates mask and restarts count (R6)
        v(1,4'h2,8'h5A,8'h00,0,4'd6), v(0,4'h2,8'h00,8'h5A,1,4'd6),
        v(0,4'h2,8'h00,8'h5A,1,4'd6), v(0,4'h2,8'h00,8'h5A,1,4'd6),
        v(1,4'h2,8'h5B,8'h00,0,4'd6),
        v(0,4'h2,8'h00,8'h5B,1,4'd6), v(0,4'h2,8'h00,8'h5B,1,4'd6), v(0,4'h2,8'h00,8'h5B,1,4'd6),
        v(0,4'h2,8'h00,8'h5B,1,4'd4), v(0,4'h2,8'h00,8'hA0,1,4'd6), v(0,4'h3,8'h00,8'h00,1,4'd6),
        // 75-89 palette index and phase logic (R10)
        v(1,4'h0,8'hFE,8'h00,0,4'd10), v(0,4'h0,8'h00,8'hFE,1,4'd10),
        v(1,4'h1,8'h01,8'h00,0,4'd10), v(1,4'h1,8'h02,8'h00,0,4'd10), v(1,4'h1,8'h03,8'h00,0,4'd10),
        v(0,4'h0,8'h00,8'hFF,1,4'd10),
        v(1,4'h1,8'h01,8'h00,0,4'd10), v(1,4'h1,8'h02,8'h00,0,4'd10), v(1,4'h1,8'h03,8'h00,0,4'd10),
        v(0,4'h0,8'h00,8'h00,1,4'd10),
        v(1,4'h3,8'h10,8'h00,0,4'd10),
        v(0,4'h1,8'h00,8'h00,1,4'd10), v(0,4'h1,8'h00,8'h00,1,4'd10), v(0,4'h1,8'h00,8'h00,1,4'd10),
        v(0,4'h3,8'h00,8'h11,1,4'd10),
        // 90-98 unused slots (R11, R2)
        v(1,4'hA,8'h77,8'h00,0,4'd11), v(0,4'hA,8'h00,8'h00,1,4'd11),
        v(0,4'h2,8'h00,8'h5B,1,4'd11), v(0,4'h6,8'h00,8'hA0,1,4'd11),
        v(0,4'h8,8'h00,8'h00,1,4'd11), v(0,4'hF,8'h00,8'h00,1,4'd11),
        v(1,4'hC,8'h55,8'h00,0,4'd2), v(0,4'h4,8'h00,8'h00,1,4'd2), v(0,4'hC,8'h00,8'h00,1,4'd2)
    };

    task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One access: drive after a falling edge, sample read data, commit at rise.
    task automatic access(input logic w, input logic r, input logic [3:0] s,
                          input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        host_sel  = s[3:2];
        host_addr = s[1:0];
        wr_stb    = w;
        rd_stb    = r;
        wr_data   = d;
        #1 q = rd_data;
        @(negedge clk);
        wr_stb = 1'b0;
        rd_stb = 1'b0;
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check8("R1 mask", pix_mask, 8'hFF);
        check8("R1 cmd", {5'd0, cmd_hicolor, cmd_sixteen, cmd_two_clk}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] e;
            e = VEC[i];
            access(e[25], !e[25], e[24:21], e[20:13], q);
            if (e[4]) check8($sformatf("R%0d vec%0d", e[3:0], i + 1), q, e[12:5]);
        end

        // R3: exported command bits after A0h (bit7=1, bit6=0, bit5=1)
        check8("R3 cmd outputs", {5'd0, cmd_hicolor, cmd_sixteen, cmd_two_clk}, 8'h05);
        check8("R11 mask output", pix_mask, 8'h5B);

        // R11: simultaneous strobes act as a write
        access(1'b1, 1'b1, 4'h2, 8'h33, q);
        check8("R11 write wins", pix_mask, 8'h33);

        // R1: reset mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check8("R1 mask after reset", pix_mask, 8'hFF);
        check8("R1 cmd after reset", {5'd0, cmd_hicolor, cmd_sixteen, cmd_two_clk}, 8'h00);
        access(1'b0, 1'b1, 4'h0, 8'h00, q);
        check8("R1 palette index after reset", q, 8'h00);
        access(1'b0, 1'b1, 4'h5, 8'h00, q);
        check8("R1 overlay entry after reset", q, 8'h00);

        done = 1'b1;
        finish_run();
    end

endmodule